// File: doc/BRIEF.md
# Configurable UART Frame Receiver

This block turns an asynchronous serial line into parallel characters. The line is oversampled by a 16x tick, which acts as a clock enable on the system clock. A falling edge on the idle-high line starts a character. The receiver then collects 5 to 8 data bits, least significant bit first. An optional parity bit follows, then the stop bit. The character format comes from a 6-bit control word that is shared with the transmitter. It can be changed at run time while the line is idle.

The receiver confirms a start bit only if the line is still low half a bit time after the edge, so short glitches on the line do not produce characters. Each completed character lands in an output holding register with a data-ready flag. Parity error, framing error and overrun flags come with it. A one-cycle read strobe from the host consumes the character and clears all four flags. The serial input passes through a synchronizer, and the external active-low reset is released synchronously inside the block.

Top module: `uart_frame_rx`

## Requirements
- R1: After reset, rx_data is 0 and data_ready, parity_err, frame_err and overrun are all 0.
- R2: Word length follows ctrl[1:0]: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Bits arrive LSB first. Each bit is sampled at its middle (16 ticks per bit). Unused upper bits of rx_data read 0.
- R3: With ctrl[3]=1 and ctrl[5]=0, one parity bit follows the data. ctrl[4]=0 demands an odd total count of ones over data plus parity, and ctrl[4]=1 demands an even count. A mismatch sets parity_err with the character.
- R4: With ctrl[3]=1 and ctrl[5]=1, the parity bit must equal the inverse of ctrl[4]: 1 when ctrl[4]=0, and 0 when ctrl[4]=1. Otherwise parity_err is set.
- R5: With ctrl[3]=0, no parity bit is expected, and parity_err stays 0.
- R6: frame_err is set with a character whose first stop bit samples low. ctrl[2] (stop count) has no effect on reception.
- R7: A low pulse that has ended by the start-bit mid-point, 8 ticks after the falling edge is seen, is discarded. No character and no flag result.
- R8: If a character completes while data_ready is still 1 and no read strobe is present, overrun is set. rx_data then holds the newer character.
- R9: A read strobe clears data_ready, overrun, parity_err and frame_err. A character completing in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Oversampling enable, 16 per bit time |
| ctrl | input | 6 | Format word: [1:0] length, [2] stop count, [3] parity on, [4] even, [5] forced |
| rx_in | input | 1 | Serial input, idle high |
| rd_strobe | input | 1 | Host has consumed the character |
| rx_data | output | 8 | Received character, zero-extended |
| data_ready | output | 1 | Unread character present |
| parity_err | output | 1 | Parity check failed on held character |
| frame_err | output | 1 | Stop bit low on held character |
| overrun | output | 1 | A character arrived before the previous one was read |

## Verification
The assertions assume that ctrl changes only while the line is idle and no character is held. The check that upper data bits are zero reads the current length field, so a change of length under a held character would break that check falsely. The bench therefore reads each character before it loads the next control word, and it keeps the line high between frames. The tick is a regular one-in-two enable. The bench drives each serial bit for exactly 16 ticks, so mid-bit samples never fall on a transition.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef enum logic [2:0] {
    RX_IDLE  = 3'd0,
    RX_START = 3'd1,
    RX_DATA  = 3'd2,
    RX_PAR   = 3'd3,
    RX_STOP  = 3'd4
  } rx_state_e;
endpackage

// File: rtl/rxf_sync.sv
module rxf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_n;

  generate
    if (STAGES == 1) begin : g_one
      always_comb pipe_n = d_in;
    end else begin : g_many
      always_comb pipe_n = {pipe_q[STAGES-2:0], d_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= pipe_n;
  end

  assign q_out = pipe_q[STAGES-1];
endmodule

// File: rtl/rxf_core.sv
module rxf_core
  import rxf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rx,
  input  logic [1:0]        len,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              par_force,
  output logic              done,
  output logic [DATA_W-1:0] done_data,
  output logic              done_pe,
  output logic              done_fe
);
  localparam int CNT_W = $clog2(OSR);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(OSR/2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);

  rx_state_e         st_q, st_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic [DATA_W-1:0] sh_q, sh_n;
  logic              pbit_q, pbit_n;

  logic [1:0]        shamt;
  logic              last_bit;
  logic              ones;

  assign shamt    = 2'd3 - len;
  assign last_bit = (idx_q == (IDX_W'(DATA_W - 1) - IDX_W'(shamt)));

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    idx_n  = idx_q;
    sh_n   = sh_q;
    pbit_n = pbit_q;
    done   = 1'b0;
    if (tick) begin
      case (st_q)
        RX_IDLE: begin
          if (!rx) begin
            st_n  = RX_START;
            cnt_n = '0;
          end
        end
        RX_START: begin
          if (cnt_q == HALF) begin
            cnt_n = '0;
            idx_n = '0;
            st_n  = rx ? RX_IDLE : RX_DATA;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt_q == LAST) begin
            cnt_n = '0;
            sh_n  = {rx, sh_q[DATA_W-1:1]};
            if (last_bit) st_n = par_en ? RX_PAR : RX_STOP;
            else          idx_n = idx_q + 1'b1;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        RX_PAR: begin
          if (cnt_q == LAST) begin
            cnt_n  = '0;
            pbit_n = rx;
            st_n   = RX_STOP;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (cnt_q == LAST) begin
            cnt_n = '0;
            done  = 1'b1;
            st_n  = RX_IDLE;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        default: st_n = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      pbit_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      idx_q  <= idx_n;
      sh_q   <= sh_n;
      pbit_q <= pbit_n;
    end
  end

  // Character result, valid in the cycle done is high
  assign done_data = sh_q >> shamt;
  assign ones      = (^done_data) ^ pbit_q;
  assign done_fe   = ~rx;
  always_comb begin
    if (!par_en)        done_pe = 1'b0;
    else if (par_force) done_pe = (pbit_q == par_even);
    else                done_pe = par_even ? ones : ~ones;
  end

  // R2: bit index stays inside the programmed word length
  p_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RX_DATA) |-> (idx_q <= (IDX_W'(DATA_W - 1) - IDX_W'(shamt))));

  // R7: a start bit found high at its mid-point returns to idle
  p_false_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RX_START && tick && cnt_q == HALF && rx) |=> (st_q == RX_IDLE));

  // R5: a frame without parity never visits the parity state
  p_no_par_state_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RX_PAR) |-> par_en);

  // R6: characters complete only from the stop state
  p_done_from_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (st_q == RX_STOP && tick));
endmodule

// File: rtl/rxf_flags.sv
module rxf_flags #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [DATA_W-1:0] done_data,
  input  logic              done_pe,
  input  logic              done_fe,
  input  logic              rd,
  input  logic [1:0]        len,
  output logic [DATA_W-1:0] data,
  output logic              ready,
  output logic              pe,
  output logic              fe,
  output logic              ovr
);
  logic [DATA_W-1:0] data_n;
  logic              ready_n, pe_n, fe_n, ovr_n;
  logic [DATA_W-1:0] len_mask;

  assign len_mask = {DATA_W{1'b1}} >> (2'd3 - len);

  always_comb begin
    data_n  = data;
    ready_n = ready;
    pe_n    = pe;
    fe_n    = fe;
    ovr_n   = ovr;
    if (rd) begin
      ready_n = 1'b0;
      pe_n    = 1'b0;
      fe_n    = 1'b0;
      ovr_n   = 1'b0;
    end
    if (done) begin
      data_n  = done_data;
      ready_n = 1'b1;
      pe_n    = done_pe;
      fe_n    = done_fe;
      ovr_n   = ovr_n | (ready & ~rd);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data  <= '0;
      ready <= 1'b0;
      pe    <= 1'b0;
      fe    <= 1'b0;
      ovr   <= 1'b0;
    end else begin
      data  <= data_n;
      ready <= ready_n;
      pe    <= pe_n;
      fe    <= fe_n;
      ovr   <= ovr_n;
    end
  end

  p_ready_on_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ready);

  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> ((data & ~len_mask) == '0));

  p_ovr_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> $past(ready));

  p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !done) |=> (!ready && !ovr && !pe && !fe));
endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx #(
  parameter int DATA_W      = 8,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              tick16,
  input  logic [5:0]        ctrl,
  input  logic              rx_in,
  input  logic              rd_strobe,
  output logic [DATA_W-1:0] rx_data,
  output logic              data_ready,
  output logic              parity_err,
  output logic              frame_err,
  output logic              overrun
);
  logic [1:0]        rst_pipe_q;
  logic              rst_n;
  logic              rx_s;
  logic              done;
  logic [DATA_W-1:0] done_data;
  logic              done_pe, done_fe;
  logic              unused_stop_sel;

  assign unused_stop_sel = ctrl[2];

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n = rst_pipe_q[1];

  rxf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (rx_in),
    .q_out (rx_s)
  );

  rxf_core #(.DATA_W(DATA_W), .OSR(OSR)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick16),
    .rx        (rx_s),
    .len       (ctrl[1:0]),
    .par_en    (ctrl[3]),
    .par_even  (ctrl[4]),
    .par_force (ctrl[5]),
    .done      (done),
    .done_data (done_data),
    .done_pe   (done_pe),
    .done_fe   (done_fe)
  );

  rxf_flags #(.DATA_W(DATA_W)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .done      (done),
    .done_data (done_data),
    .done_pe   (done_pe),
    .done_fe   (done_fe),
    .rd        (rd_strobe),
    .len       (ctrl[1:0]),
    .data      (rx_data),
    .ready     (data_ready),
    .pe        (parity_err),
    .fe        (frame_err),
    .ovr       (overrun)
  );

  // R1: flags are clear in the first cycle after reset release
  p_reset_clear_r1: assert property (@(posedge clk)
    (rst_n && !$past(rst_n)) |-> (!data_ready && !overrun && !parity_err && !frame_err));
endmodule

// File: tb/uart_frame_rx_bench.sv
module uart_frame_rx_bench;
  logic       clk = 1'b0;
  logic       arst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic [5:0] ctrl = 6'h03;
  logic       rx_in = 1'b1;
  logic       rd_strobe = 1'b0;
  logic [7:0] rx_data;
  logic       data_ready, parity_err, frame_err, overrun;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  localparam int BIT_CLKS = 32; // tick every 2 clocks, 16 ticks per bit

  // {ctrl[7:0], data[7:0], flip parity, stop bit}
  localparam logic [17:0] VEC [10] = '{
    {8'h03, 8'hA5, 1'b0, 1'b1},
    {8'h00, 8'hFF, 1'b0, 1'b1},
    {8'h01, 8'hC3, 1'b0, 1'b1},
    {8'h0A, 8'h5A, 1'b0, 1'b1},
    {8'h1B, 8'h37, 1'b0, 1'b1},
    {8'h1B, 8'h37, 1'b1, 1'b1},
    {8'h2B, 8'h81, 1'b0, 1'b1},
    {8'h3A, 8'h6E, 1'b1, 1'b1},
    {8'h07, 8'h3C, 1'b0, 1'b0},
    {8'h0B, 8'hF0, 1'b1, 1'b0}
  };

  uart_frame_rx u_uart_frame_rx (
    .clk        (clk),
    .arst_n     (arst_n),
    .tick16     (tick16),
    .ctrl       (ctrl),
    .rx_in      (rx_in),
    .rd_strobe  (rd_strobe),
    .rx_data    (rx_data),
    .data_ready (data_ready),
    .parity_err (parity_err),
    .frame_err  (frame_err),
    .overrun    (overrun)
  );

  always #4 clk = ~clk;

  initial forever begin
    @(negedge clk);
    tick16 = ~tick16;
  end

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle_bits(input int n);
    rx_in = 1'b1;
    repeat (n * BIT_CLKS) @(negedge clk);
  endtask

  task automatic send_frame(input logic [5:0] c, input logic [7:0] d, input logic flip, input logic stopv);
    int nb;
    logic [7:0] m;
    logic pbit;
    nb = 5 + int'(c[1:0]);
    m  = 8'hFF >> (8 - nb);
    if (c[5]) pbit = ~c[4];
    else      pbit = c[4] ? (^(d & m)) : ~(^(d & m));
    pbit = pbit ^ flip;
    rx_in = 1'b0;
    repeat (BIT_CLKS) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rx_in = d[i];
      repeat (BIT_CLKS) @(negedge clk);
    end
    if (c[3]) begin
      rx_in = pbit;
      repeat (BIT_CLKS) @(negedge clk);
    end
    rx_in = stopv;
    repeat (BIT_CLKS) @(negedge clk);
    rx_in = 1'b1;
  endtask

  task automatic read_pulse;
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    arst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1: reset state
    check("R1", "rx_data", rx_data, 8'h00);
    check("R1", "flags", {4'b0, data_ready, parity_err, frame_err, overrun}, 8'h00);
    idle_bits(2);

    // Vector walk: R2 lengths, R3 odd/even, R4 forced, R5 none, R6 framing
    for (int v = 0; v < 10; v++) begin
      logic [5:0] c;
      logic [7:0] d, m;
      logic flip, stopv;
      c     = VEC[v][15:10];
      d     = VEC[v][9:2];
      flip  = VEC[v][1];
      stopv = VEC[v][0];
      ctrl  = c;
      m     = 8'hFF >> (3 - int'(c[1:0]));
      idle_bits(1);
      send_frame(c, d, flip, stopv);
      idle_bits(1);
      check("R2", "data_ready", {7'b0, data_ready}, 8'h01);
      check("R2", "rx_data", rx_data, d & m);
      check(c[5] ? "R4" : (c[3] ? "R3" : "R5"), "parity_err", {7'b0, parity_err}, {7'b0, flip & c[3]});
      check("R6", "frame_err", {7'b0, frame_err}, {7'b0, ~stopv});
      check("R8", "overrun", {7'b0, overrun}, 8'h00);
      read_pulse();
      check("R9", "flags after read", {4'b0, data_ready, parity_err, frame_err, overrun}, 8'h00);
    end

    // R7: false start pulse of 6 ticks
    ctrl = 6'h03;
    idle_bits(1);
    rx_in = 1'b0;
    repeat (12) @(negedge clk);
    rx_in = 1'b1;
    idle_bits(12);
    check("R7", "data_ready after glitch", {7'b0, data_ready}, 8'h00);
    check("R7", "frame_err after glitch", {7'b0, frame_err}, 8'h00);
    // a real character still works after the glitch
    send_frame(6'h03, 8'h4D, 1'b0, 1'b1);
    idle_bits(1);
    check("R7", "data after glitch", rx_data, 8'h4D);

    // R8: second character without read
    send_frame(6'h03, 8'h96, 1'b0, 1'b1);
    idle_bits(1);
    check("R8", "overrun", {7'b0, overrun}, 8'h01);
    check("R8", "newer data", rx_data, 8'h96);
    check("R8", "data_ready", {7'b0, data_ready}, 8'h01);
    read_pulse();
    check("R9", "overrun cleared", {7'b0, overrun}, 8'h00);
    check("R9", "ready cleared", {7'b0, data_ready}, 8'h00);

    // R6: stop count bit has no effect on 8-bit reception with high stop
    ctrl = 6'h07;
    send_frame(6'h07, 8'h11, 1'b0, 1'b1);
    idle_bits(1);
    check("R6", "frame_err with ctrl[2]", {7'b0, frame_err}, 8'h00);
    check("R6", "data with ctrl[2]", rx_data, 8'h11);
    read_pulse();

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule